// File: doc/BRIEF.md
# SD Host Command Issue Unit

This unit is the register-level front end that launches commands for an SD card host. Software first writes a command argument. It may also write a timeout start value. It then writes the command word with its launch flag set. The unit passes the command index, the argument and the response style to a command-line engine with a one-cycle start pulse. It then waits for the engine to report completion, a CRC failure or nothing at all.

A good response is stored in the response words. A long response fills four words and a short one fills only the lowest. When the command asks for it, the unit also waits for the card to drop its busy signal. At the end it clears the launch flag, which is the software completion poll. A failure sets a sticky fail flag in the command word and a cause bit in a write-1-to-clear status register.

Registers are word-addressed. Address 0 holds the command word, 1 the argument, 2 the timeout start value and 3 the status. Addresses 4 to 7 hold the response words.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, every register reads zero and `eng_start_o` is low.
- R2: Writing the command word at address 0 with bit 15 set while bit 15 is clear starts a command. Bit 15 reads 1 from the next cycle. In that next cycle `eng_start_o` is high for exactly one cycle, with `eng_index_o` taken from bits 5:0, `eng_long_o` from bit 9 and `eng_no_rsp_o` from bit 10.
- R3: Bit 15 clears on the clock edge where the command ends. That edge is the one where `eng_done_i` is sampled, unless busy-wait applies.
- R4: On a good completion, response word 0 (address 4) takes `eng_rsp_i[31:0]`. If bit 9 is set, addresses 5, 6 and 7 take bits 63:32, 95:64 and 127:96. A short command leaves addresses 5 to 7 unchanged. A command with bit 10 set leaves all response words unchanged.
- R5: A completion with `eng_crc_err_i` high sets bit 14 of the command word and status bit 4, clears bit 15, and changes no response word.
- R6: At start, a countdown is loaded from address 2. It drops by one in each waiting cycle without `eng_done_i`. For a start value N, a completion is accepted in waiting cycles 0 to N. If the count is zero and no completion arrives, bit 14 and status bit 6 are set and bit 15 clears.
- R7: With bit 11 set, a good completion is followed by a wait while `card_busy_i` is high. Bit 15 stays set during the wait. On the first edge with `card_busy_i` low, status bit 10 is set and bit 15 clears.
- R8: Writing the status register clears each status bit written as 1. A cause that arrives in the same cycle wins over the clear. Only status bits 10, 6 and 4 can become set; all other status bits read zero.
- R9: A write to the command word while bit 15 is set changes nothing and starts nothing.
- R10: Bit 14 stays set until the next command launch clears it. Command bits 8, 12 and 13 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| eng_start_o | output | 1 | One-cycle command start to the engine |
| eng_index_o | output | 6 | Command index |
| eng_arg_o | output | DATA_W | Command argument |
| eng_long_o | output | 1 | Long response expected |
| eng_no_rsp_o | output | 1 | No response expected |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_crc_err_i | input | 1 | Response CRC failed, valid with done |
| eng_rsp_i | input | RSP_WORDS*DATA_W | Received response bits, valid with done |
| card_busy_i | input | 1 | Card holds busy |

## Verification
If the sequencer lost its phase, the fault would show within one cycle. The start pulse would be missing, repeated or late, and the launch flag at address 0 would not read back as predicted. A corrupted countdown would end a command one cycle earlier or later than the timeout start value allows. The bench therefore probes the exact accept and expire cycles. A bad capture or status path would show at the next read of addresses 3 to 7. The per-clock comparison of the read port and start pulse against the bench model pins such faults to the exact cycle.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int STAT_W = 11;
  localparam int IDX_W  = 6;

  // command word bit positions
  localparam int B_LONG  = 9;
  localparam int B_NORSP = 10;
  localparam int B_BUSYW = 11;
  localparam int B_FAIL  = 14;
  localparam int B_NEW   = 15;
  localparam logic [CMD_W-1:0] CMD_FIELDS = 16'h0EFF;

  // status bit positions
  localparam int S_BUSY = 10;
  localparam int S_CTO  = 6;
  localparam int S_CRC7 = 4;
  localparam logic [STAT_W-1:0] STAT_IMPL = 11'h450;

  // low-half register addresses
  localparam int A_CMD  = 0;
  localparam int A_ARG  = 1;
  localparam int A_TOUT = 2;
  localparam int A_STAT = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_HOLD} phase_e;
endpackage

// File: rtl/sd_cmd_timer.sv
module sd_cmd_timer #(
  parameter int TOUT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TOUT_W-1:0] start_i,
  input  logic              dec_i,
  output logic              zero_o
);
  localparam logic [TOUT_W-1:0] ONE = {{(TOUT_W-1){1'b0}}, 1'b1};

  logic [TOUT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= start_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             eng_done_i,
  input  logic             eng_crc_err_i,
  input  logic             card_busy_i,
  input  logic             tmr_zero_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             eng_start_o,
  output logic             tmr_load_o,
  output logic             tmr_dec_o,
  output logic             cap_o,
  output logic             set_cto_o,
  output logic             set_crc_o,
  output logic             set_busy_o
);
  phase_e           ph_q, ph_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             waiting, rsp_ok, rsp_bad, expired, released;

  assign waiting  = (ph_q == PH_WAIT);
  assign rsp_ok   = waiting & eng_done_i & ~eng_crc_err_i;
  assign rsp_bad  = waiting & eng_done_i & eng_crc_err_i;
  assign expired  = waiting & ~eng_done_i & tmr_zero_i;
  assign released = (ph_q == PH_HOLD) & ~card_busy_i;

  always_comb begin
    ph_d  = ph_q;
    cmd_d = cmd_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (wr_cmd_i) begin
          cmd_d = (cmd_q & ~CMD_FIELDS) | (cmd_wdata_i & CMD_FIELDS);
          if (cmd_wdata_i[B_NEW]) begin
            cmd_d[B_NEW]  = 1'b1;
            cmd_d[B_FAIL] = 1'b0;
            ph_d          = PH_ISSUE;
          end
        end
      end
      PH_ISSUE: ph_d = PH_WAIT;
      PH_WAIT: begin
        if (rsp_bad || expired) begin
          cmd_d[B_FAIL] = 1'b1;
          cmd_d[B_NEW]  = 1'b0;
          ph_d          = PH_IDLE;
        end else if (rsp_ok) begin
          if (cmd_q[B_BUSYW]) begin
            ph_d = PH_HOLD;
          end else begin
            cmd_d[B_NEW] = 1'b0;
            ph_d         = PH_IDLE;
          end
        end
      end
      PH_HOLD: begin
        if (released) begin
          cmd_d[B_NEW] = 1'b0;
          ph_d         = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cmd_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cmd_q <= cmd_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign eng_start_o = (ph_q == PH_ISSUE);
  assign tmr_load_o  = (ph_q == PH_ISSUE);
  assign tmr_dec_o   = waiting & ~eng_done_i;
  assign cap_o       = rsp_ok & ~cmd_q[B_NORSP];
  assign set_crc_o   = rsp_bad;
  assign set_cto_o   = expired;
  assign set_busy_o  = released;
endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [CMD_W-1:0]            cmd_i,
  input  logic                        cap_i,
  input  logic                        long_i,
  input  logic [RSP_WORDS*DATA_W-1:0] rsp_i,
  input  logic                        set_busy_i,
  input  logic                        set_cto_i,
  input  logic                        set_crc_i,
  output logic [DATA_W-1:0]           arg_o,
  output logic [DATA_W-1:0]           tout_o,
  output logic [STAT_W-1:0]           stat_o,
  output logic [DATA_W-1:0]           rsp_lo_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int RSP_IW = $clog2(RSP_WORDS);

  logic [DATA_W-1:0] arg_q, tout_q;
  logic [STAT_W-1:0] stat_q, set_vec, clr_vec;
  logic [DATA_W-1:0] rsp_q [RSP_WORDS];
  logic              wr_low;

  // upper half of the address space is the response window
  assign wr_low = wr_en_i & ~addr_i[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q  <= '0;
      tout_q <= '0;
    end else begin
      if (wr_low && addr_i[ADDR_W-2:0] == (ADDR_W-1)'(A_ARG))  arg_q  <= wdata_i;
      if (wr_low && addr_i[ADDR_W-2:0] == (ADDR_W-1)'(A_TOUT)) tout_q <= wdata_i;
    end
  end

  always_comb begin
    set_vec         = '0;
    set_vec[S_BUSY] = set_busy_i;
    set_vec[S_CTO]  = set_cto_i;
    set_vec[S_CRC7] = set_crc_i;
    clr_vec = (wr_low && addr_i[ADDR_W-2:0] == (ADDR_W-1)'(A_STAT)) ?
              wdata_i[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (set_vec | (stat_q & ~clr_vec)) & STAT_IMPL;
  end

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        rsp_q[w] <= '0;
      else if (cap_i && (w == 0 || long_i))
        rsp_q[w] <= rsp_i[w*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (addr_i[ADDR_W-1]) begin
      rdata_o = rsp_q[addr_i[RSP_IW-1:0]];
    end else begin
      unique case (addr_i[ADDR_W-2:0])
        (ADDR_W-1)'(A_CMD):  rdata_o = DATA_W'(cmd_i);
        (ADDR_W-1)'(A_ARG):  rdata_o = arg_q;
        (ADDR_W-1)'(A_TOUT): rdata_o = tout_q;
        default:             rdata_o = DATA_W'(stat_q);
      endcase
    end
  end

  assign arg_o    = arg_q;
  assign tout_o   = tout_q;
  assign stat_o   = stat_q;
  assign rsp_lo_o = rsp_q[0];
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sd_cmd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int ADDR_W    = $clog2(RSP_WORDS) + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        eng_start_o,
  output logic [IDX_W-1:0]            eng_index_o,
  output logic [DATA_W-1:0]           eng_arg_o,
  output logic                        eng_long_o,
  output logic                        eng_no_rsp_o,
  input  logic                        eng_done_i,
  input  logic                        eng_crc_err_i,
  input  logic [RSP_WORDS*DATA_W-1:0] eng_rsp_i,
  input  logic                        card_busy_i
);
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] rsp0_q, arg_q, tout_q;
  logic              wr_cmd, tmr_zero, tmr_load, tmr_dec, cap;
  logic              set_busy, set_cto, set_crc;

  assign wr_cmd = wr_en_i && (addr_i == ADDR_W'(A_CMD));

  sd_cmd_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_cmd_i      (wr_cmd),
    .cmd_wdata_i   (wdata_i[CMD_W-1:0]),
    .eng_done_i    (eng_done_i),
    .eng_crc_err_i (eng_crc_err_i),
    .card_busy_i   (card_busy_i),
    .tmr_zero_i    (tmr_zero),
    .cmd_o         (cmd_q),
    .eng_start_o   (eng_start_o),
    .tmr_load_o    (tmr_load),
    .tmr_dec_o     (tmr_dec),
    .cap_o         (cap),
    .set_cto_o     (set_cto),
    .set_crc_o     (set_crc),
    .set_busy_o    (set_busy)
  );

  sd_cmd_timer #(.TOUT_W(DATA_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .start_i (tout_q),
    .dec_i   (tmr_dec),
    .zero_o  (tmr_zero)
  );

  sd_cmd_regs #(.DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cmd_i      (cmd_q),
    .cap_i      (cap),
    .long_i     (cmd_q[B_LONG]),
    .rsp_i      (eng_rsp_i),
    .set_busy_i (set_busy),
    .set_cto_i  (set_cto),
    .set_crc_i  (set_crc),
    .arg_o      (arg_q),
    .tout_o     (tout_q),
    .stat_o     (stat_q),
    .rsp_lo_o   (rsp0_q),
    .rdata_o    (rdata_o)
  );

  assign eng_index_o  = cmd_q[IDX_W-1:0];
  assign eng_arg_o    = arg_q;
  assign eng_long_o   = cmd_q[B_LONG];
  assign eng_no_rsp_o = cmd_q[B_NORSP];
endmodule

// File: rtl/sd_cmd_checker.sv
module sd_cmd_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              eng_start_o,
  input logic              eng_done_i,
  input logic              card_busy_i,
  input logic              new_f,
  input logic              fail_f,
  input logic [11:0]       fields,
  input logic              busy_st,
  input logic              cto_st,
  input logic              crc_st,
  input logic [DATA_W-1:0] rsp0_q
);
  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_start_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> new_f);

  p_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && new_f) |=> $stable(fields));

  p_rsp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_done_i |=> $stable(rsp0_q));

  p_crc_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_st) |-> (fail_f && !new_f));

  p_cto_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cto_st) |-> (fail_f && !new_f));

  p_busy_rel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_st) |-> (!new_f && !$past(card_busy_i)));
endmodule

bind sd_cmd_issuer sd_cmd_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .eng_start_o (eng_start_o),
  .eng_done_i  (eng_done_i),
  .card_busy_i (card_busy_i),
  .new_f       (cmd_q[15]),
  .fail_f      (cmd_q[14]),
  .fields      (cmd_q[11:0]),
  .busy_st     (stat_q[10]),
  .cto_st      (stat_q[6]),
  .crc_st      (stat_q[4]),
  .rsp0_q      (rsp0_q)
);

// File: tb/tb_sd_cmd_issuer.sv
`timescale 1ns/1ps
module tb_sd_cmd_issuer;
  localparam int DW = 32;
  localparam int RW = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           eng_start, eng_long, eng_no_rsp;
  logic [5:0]     eng_index;
  logic [DW-1:0]  eng_arg;
  logic           eng_done = 1'b0, eng_crc = 1'b0, card_busy = 1'b0;
  logic [RW*DW-1:0] eng_rsp = '0;

  sd_cmd_issuer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .eng_start_o(eng_start), .eng_index_o(eng_index),
    .eng_arg_o(eng_arg), .eng_long_o(eng_long), .eng_no_rsp_o(eng_no_rsp),
    .eng_done_i(eng_done), .eng_crc_err_i(eng_crc), .eng_rsp_i(eng_rsp),
    .card_busy_i(card_busy)
  );

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
    end
  endtask

  // ---------------- card-side responder ----------------
  int         r_delay = 1;
  bit         r_respond = 1'b1, r_crc = 1'b0;
  logic [127:0] r_data = '0;
  int         r_busy = 0;
  int         cd = 0, bc = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; eng_crc = 1'b0; card_busy = 1'b0; cd = 0; bc = 0;
    end else begin
      eng_done = 1'b0;
      if (bc > 0) begin bc--; card_busy = (bc > 0); end
      if (eng_start) cd = r_delay;
      else if (cd > 0) begin
        cd--;
        if (cd == 0 && r_respond) begin
          eng_done = 1'b1; eng_crc = r_crc; eng_rsp = r_data;
          if (!r_crc && r_busy > 0) begin bc = r_busy; card_busy = 1'b1; end
        end
      end
    end
  end

  // ---------------- reference model ----------------
  int          m_phase, m_cnt;
  logic [15:0] m_cmd;
  logic [10:0] m_stat, m_set, m_clr;
  logic [31:0] m_arg, m_tout;
  logic [31:0] m_rsp [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_cmd = '0; m_stat = '0; m_arg = '0; m_tout = '0;
      for (int i = 0; i < 4; i++) m_rsp[i] = '0;
    end else begin
      m_set = '0;
      case (m_phase)
        0: if (wr_en && addr == 0) begin
             m_cmd[11:0] = wdata[11:0] & 12'hEFF;
             if (wdata[15]) begin m_cmd[15] = 1'b1; m_cmd[14] = 1'b0; m_phase = 1; end
           end
        1: begin m_phase = 2; m_cnt = m_tout; end
        2: if (eng_done) begin
             if (eng_crc) begin
               m_cmd[14] = 1'b1; m_cmd[15] = 1'b0; m_set[4] = 1'b1; m_phase = 0;
             end else begin
               if (!m_cmd[10]) begin
                 m_rsp[0] = eng_rsp[31:0];
                 if (m_cmd[9]) for (int i = 1; i < 4; i++) m_rsp[i] = eng_rsp[i*32 +: 32];
               end
               if (m_cmd[11]) m_phase = 3;
               else begin m_cmd[15] = 1'b0; m_phase = 0; end
             end
           end else if (m_cnt == 0) begin
             m_cmd[14] = 1'b1; m_cmd[15] = 1'b0; m_set[6] = 1'b1; m_phase = 0;
           end else m_cnt--;
        3: if (!card_busy) begin m_set[10] = 1'b1; m_cmd[15] = 1'b0; m_phase = 0; end
        default: m_phase = 0;
      endcase
      m_clr = (wr_en && addr == 3) ? wdata[10:0] : '0;
      m_stat = (m_stat & ~m_clr) | m_set;
      if (wr_en && addr == 1) m_arg = wdata;
      if (wr_en && addr == 2) m_tout = wdata;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_cmd};
      3'd1: return m_arg;
      3'd2: return m_tout;
      3'd3: return {21'h0, m_stat};
      default: return m_rsp[a[1:0]];
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd3: return "R8";
      3'd1, 3'd2: return "R6";
      default: return "R4";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      #1;
      check(tag_of(addr), rdata, m_read(addr));
      check("R2", {31'h0, eng_start}, {31'h0, m_phase == 1});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic issue(input logic [15:0] c);
    wr(3'd0, {16'h0, c | 16'h8000});
    #1;
    check("R2", {31'h0, eng_start}, 32'h1);
    check("R2", {26'h0, eng_index}, {26'h0, c[5:0]});
    check("R2", {30'h0, eng_long, eng_no_rsp}, {30'h0, c[9], c[10]});
  endtask

  task automatic wait_done();
    logic [31:0] v;
    v = 32'h8000;
    for (int i = 0; i < 500; i++) begin
      rd(3'd0, v);
      if (!v[15]) break;
    end
    check("R3", {31'h0, v[15]}, 32'h0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R1", v, 32'h0);
    end
    check("R1", {31'h0, eng_start}, 32'h0);

    wr(3'd2, 32'd100);
    wr(3'd1, 32'hCAFE_0001);

    // R3 R4: short response
    r_delay = 3;
    r_data = 128'h44444444_33333333_22222222_11111111;
    issue(16'h0011);
    check("R2", eng_arg, 32'hCAFE_0001);
    wait_done();
    rd(3'd4, v); check("R4", v, 32'h11111111);
    rd(3'd5, v); check("R4", v, 32'h0);
    rd(3'd0, v); check("R3", v, 32'h0011);

    // R4: long response
    r_data = 128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA;
    issue(16'h0202);
    wait_done();
    rd(3'd4, v); check("R4", v, 32'hAAAAAAAA);
    rd(3'd5, v); check("R4", v, 32'hBBBBBBBB);
    rd(3'd6, v); check("R4", v, 32'hCCCCCCCC);
    rd(3'd7, v); check("R4", v, 32'hDDDDDDDD);

    // R4: no-response command keeps response words
    r_data = 128'h99999999_88888888_77777777_66666666;
    issue(16'h0400);
    wait_done();
    rd(3'd4, v); check("R4", v, 32'hAAAAAAAA);

    // R5: CRC error
    r_crc = 1'b1;
    issue(16'h0203);
    wait_done();
    r_crc = 1'b0;
    rd(3'd0, v); check("R5", v, 32'h4203);
    rd(3'd3, v); check("R5", v, 32'h010);
    rd(3'd7, v); check("R5", v, 32'hDDDDDDDD);

    // R6: timeout, one cycle past the last accept cycle
    wr(3'd2, 32'd3);
    r_delay = 5;
    issue(16'h0005);
    wait_done();
    rd(3'd0, v); check("R6", v, 32'h4005);
    rd(3'd3, v); check("R6", v, 32'h050);

    // R8: write-1-to-clear only the written bit
    wr(3'd3, 32'h010);
    rd(3'd3, v); check("R8", v, 32'h040);

    // R6 R10: completion in the last accept cycle; launch clears fail
    r_delay = 4;
    issue(16'h0006);
    wait_done();
    rd(3'd0, v); check("R10", v, 32'h0006);
    rd(3'd3, v); check("R6", v, 32'h040);

    // R7: busy-wait
    wr(3'd2, 32'd100);
    r_delay = 2;
    r_busy = 6;
    issue(16'h0807);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R7", v, 32'h8807);
    wait_done();
    r_busy = 0;
    rd(3'd0, v); check("R7", v, 32'h0807);
    rd(3'd3, v); check("R7", v, 32'h440);

    // R9: command write while pending is ignored
    r_delay = 20;
    issue(16'h0008);
    wr(3'd0, 32'h0000_8209);
    wait_done();
    rd(3'd0, v); check("R9", v, 32'h0008);

    // R8: clear everything, unimplemented bits stay zero
    wr(3'd3, 32'h7FF);
    rd(3'd3, v); check("R8", v, 32'h0);

    repeat (30) @(negedge clk);
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule